// File: doc/BRIEF.md
# Four-Channel Memory-to-Memory DMA Engine

This block moves blocks of data from one region of memory to another on behalf of a processor. Software programs each of four channels through a word-addressed register bus. Each channel holds a control word, an element count, and 64-bit source and destination addresses. The engine then copies the elements through a single request/acknowledge memory port. Each channel also holds a 64-bit descriptor-chain address that is stored and read back but not acted on.

A transfer begins when the control word is written with its enable bit set while the channel's count is nonzero. A two-bit code in the control word selects the element size, which is 1, 2, 4 or 8 bytes. Two independent flags choose whether the source and the destination address advance after each element. Only one channel moves data at a time. When several channels are waiting, the lowest-numbered one is served next. A shared status register records which channels have completed, and software clears its bits by writing ones.

Top module: `dma4_engine`

## Requirements
- R1: Register word offsets are relative to the parameter BASE (default 0x80). Channel n uses offsets 8n+0 through 8n+7, in this order: control, count, source high, source low, destination high, destination low, chain high, chain low. Every one of these reads back the last value written to it, except control bit 30.
- R2: A write to one 32-bit half of a 64-bit address register replaces that half and leaves the other half unchanged.
- R3: A control write with bit 31 set starts a transfer when the low 16 bits of that channel's count register are nonzero, and the transfer copies exactly that many elements. When the low 16 bits of the count are zero, no memory access occurs and no status bit is set.
- R4: Control bits 26:25 form a code c. Each element is 2^c bytes, and `memSize` carries c on every access of the transfer.
- R5: When control bit 23 is set, the source address advances by the element size after each element; when it is clear, the source address stays fixed. Bit 24 does the same for the destination address.
- R6: Each element is handled as a read followed by a write to the destination. `memReq`, `memWe` and `memAddr` hold steady until `memAck`. Only one channel is active at a time. When the engine is idle and several channels are pending, the lowest-numbered channel is served first.
- R7: Data is little-endian. The byte at the lowest address occupies bits 7:0 of `memRdata` and `memWdata`. The element's bytes are copied unchanged, and the bits of `memWdata` above the element are zero.
- R8: The status register is at offset 0x20. Bit n is set when channel n completes its last element. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R9: Reading a channel's control register returns its busy state in bit 30. The bit is 1 from the starting control write until that channel's last element completes. Bit 30 of a written value is ignored.
- R10: Offsets other than the channel registers and the status register read as zero, and writes to them change nothing.
- R11: Reset clears every channel register, the status register and any pending or active transfer. After reset the registers still respond at offsets relative to BASE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from regAddr |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 64 | Byte address of the element |
| memSize | output | 2 | Element size code (2^code bytes) |
| memWdata | output | 64 | Write data, element in the low bytes |
| memAck | input | 1 | Memory completes the current access |
| memRdata | input | 64 | Read data, element in the low bytes |

## Verification
A corrupted working address or remaining count shows up as destination bytes that differ from a byte-level reference copy. The difference is visible as soon as the channel's status bit rises, which happens within a few cycles of the last acknowledged write. A wrong pending or arbitration state appears at the register port in two ways: a busy bit that disagrees with the expected value on the very next read, or a status bit that rises in the wrong channel order. A lane or mask fault appears on the first write of the transfer as nonzero upper bits of `memWdata` or as a misplaced byte.

// File: rtl/dma4_pkg.sv
package dma4_pkg;

  localparam int CTRL_EN_BIT   = 31;
  localparam int CTRL_BUSY_BIT = 30;
  localparam int CTRL_WID_LO   = 25;
  localparam int CTRL_DINC_BIT = 24;
  localparam int CTRL_SINC_BIT = 23;
  localparam int SLOTS_PER_CH  = 8;
  localparam int STATUS_OFF    = 'h20;

  typedef enum logic [2:0] {
    SLOT_CTRL   = 3'd0,
    SLOT_COUNT  = 3'd1,
    SLOT_SRC_HI = 3'd2,
    SLOT_SRC_LO = 3'd3,
    SLOT_DST_HI = 3'd4,
    SLOT_DST_LO = 3'd5,
    SLOT_SG_HI  = 3'd6,
    SLOT_SG_LO  = 3'd7
  } slot_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xferState_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic load;     // copy the selected channel's setup into working registers
    logic capture;  // latch read data for the current element
    logic step;     // element written: advance addresses, decrement count
    logic finish;   // last element written: clear pending, set status
  } dmaStrobe_t;

endpackage

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NUM_CH  = 4,
  localparam int CHSEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_CH-1:0]  pending,
  input  logic               lastElem,
  input  logic               memAck,
  output dmaStrobe_t         strb,
  output logic [CHSEL_W-1:0] selCh,
  output logic               memReq,
  output logic               memWe
);

  xferState_e          state;
  logic [CHSEL_W-1:0]  curCh;
  logic [CHSEL_W-1:0]  pick;

  // lowest-numbered pending channel wins
  always_comb begin
    pick = '0;
    for (int c = NUM_CH - 1; c >= 0; c--) begin
      if (pending[c]) pick = CHSEL_W'(c);
    end
  end

  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WRITE);
  assign selCh  = (state == ST_IDLE) ? pick : curCh;

  always_comb begin
    strb         = '0;
    strb.load    = (state == ST_IDLE) && (pending != '0);
    strb.capture = (state == ST_READ) && memAck;
    strb.step    = (state == ST_WRITE) && memAck;
    strb.finish  = (state == ST_WRITE) && memAck && lastElem;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (pending != '0) begin
          curCh <= pick;
          state <= ST_READ;
        end
        ST_READ:  if (memAck) state <= ST_WRITE;
        ST_WRITE: if (memAck) state <= lastElem ? ST_IDLE : ST_READ;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  // R6: an unanswered request keeps its kind and channel
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(selCh)));

  // R6: an acknowledged read is always followed by the matching write
  a_r6_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memAck) |=> (memReq && memWe));

  // R6: the granted channel is pending and no lower channel is
  a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> (pending[selCh] &&
                   ((pending & ((NUM_CH'(1) << selCh) - NUM_CH'(1))) == '0)));

endmodule

// File: rtl/dma4_datapath.sv
module dma4_datapath
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] BASE = 'h80,
  parameter int CNT_W  = 16,
  localparam int CHSEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CH_SPAN = NUM_CH * SLOTS_PER_CH
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [REG_AW-1:0]  regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  dmaStrobe_t         strb,
  input  logic [CHSEL_W-1:0] selCh,
  input  logic               isWrite,
  output logic [NUM_CH-1:0]  pending,
  output logic               lastElem,
  output logic [63:0]        memAddr,
  output logic [1:0]         memSize,
  output logic [63:0]        memWdata,
  input  logic [63:0]        memRdata
);

  logic [31:0] ctrlReg [NUM_CH];
  logic [31:0] cntReg  [NUM_CH];
  logic [63:0] srcReg  [NUM_CH];
  logic [63:0] dstReg  [NUM_CH];
  logic [63:0] sgReg   [NUM_CH];
  logic [NUM_CH-1:0] pendingR, statusR, startHit;

  logic [REG_AW-1:0]  off;
  logic               chanHit, statHit;
  logic [CHSEL_W-1:0] regCh;
  slot_e              slot;

  assign off     = regAddr - BASE;
  assign chanHit = (int'(off) < CH_SPAN);
  assign statHit = (int'(off) == STATUS_OFF);
  assign regCh   = off[3 +: CHSEL_W];
  assign slot    = slot_e'(off[2:0]);

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      startHit[c] = regWrEn && chanHit && (regCh == CHSEL_W'(c)) &&
                    (slot == SLOT_CTRL) && regWrData[CTRL_EN_BIT] &&
                    (cntReg[c][CNT_W-1:0] != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CH; c++) begin
        ctrlReg[c] <= '0;
        cntReg[c]  <= '0;
        srcReg[c]  <= '0;
        dstReg[c]  <= '0;
        sgReg[c]   <= '0;
      end
      pendingR <= '0;
      statusR  <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (regWrEn && chanHit && (regCh == CHSEL_W'(c))) begin
          unique case (slot)
            SLOT_CTRL: begin
              ctrlReg[c] <= regWrData;
              ctrlReg[c][CTRL_BUSY_BIT] <= 1'b0;
            end
            SLOT_COUNT:  cntReg[c]         <= regWrData;
            SLOT_SRC_HI: srcReg[c][63:32]  <= regWrData;
            SLOT_SRC_LO: srcReg[c][31:0]   <= regWrData;
            SLOT_DST_HI: dstReg[c][63:32]  <= regWrData;
            SLOT_DST_LO: dstReg[c][31:0]   <= regWrData;
            SLOT_SG_HI:  sgReg[c][63:32]   <= regWrData;
            SLOT_SG_LO:  sgReg[c][31:0]    <= regWrData;
            default: ;
          endcase
        end
        if (startHit[c])
          pendingR[c] <= 1'b1;
        else if (strb.finish && (selCh == CHSEL_W'(c)))
          pendingR[c] <= 1'b0;
        if (strb.finish && (selCh == CHSEL_W'(c)))
          statusR[c] <= 1'b1;
        else if (regWrEn && statHit && regWrData[c])
          statusR[c] <= 1'b0;
      end
    end
  end

  assign pending = pendingR;

  // working copy of the active channel
  logic [63:0]      curSrc, curDst, dataLatch, stepBytes;
  logic [CNT_W-1:0] remain;
  logic [1:0]       curW;
  logic             sInc, dInc;

  function automatic logic [63:0] laneMask(input logic [1:0] code);
    case (code)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  assign stepBytes = 64'd1 << curW;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSrc    <= '0;
      curDst    <= '0;
      dataLatch <= '0;
      remain    <= '0;
      curW      <= '0;
      sInc      <= 1'b0;
      dInc      <= 1'b0;
    end else begin
      if (strb.load) begin
        curSrc <= srcReg[selCh];
        curDst <= dstReg[selCh];
        remain <= cntReg[selCh][CNT_W-1:0];
        curW   <= ctrlReg[selCh][CTRL_WID_LO +: 2];
        sInc   <= ctrlReg[selCh][CTRL_SINC_BIT];
        dInc   <= ctrlReg[selCh][CTRL_DINC_BIT];
      end
      if (strb.capture) dataLatch <= memRdata & laneMask(curW);
      if (strb.step) begin
        if (sInc) curSrc <= curSrc + stepBytes;
        if (dInc) curDst <= curDst + stepBytes;
        remain <= remain - CNT_W'(1);
      end
    end
  end

  assign lastElem = (remain == CNT_W'(1));
  assign memAddr  = isWrite ? curDst : curSrc;
  assign memSize  = curW;
  assign memWdata = dataLatch;

  always_comb begin
    regRdData = '0;
    if (chanHit) begin
      unique case (slot)
        SLOT_CTRL: begin
          regRdData = ctrlReg[regCh];
          regRdData[CTRL_BUSY_BIT] = pendingR[regCh];
        end
        SLOT_COUNT:  regRdData = cntReg[regCh];
        SLOT_SRC_HI: regRdData = srcReg[regCh][63:32];
        SLOT_SRC_LO: regRdData = srcReg[regCh][31:0];
        SLOT_DST_HI: regRdData = dstReg[regCh][63:32];
        SLOT_DST_LO: regRdData = dstReg[regCh][31:0];
        SLOT_SG_HI:  regRdData = sgReg[regCh][63:32];
        SLOT_SG_LO:  regRdData = sgReg[regCh][31:0];
        default: ;
      endcase
    end else if (statHit) begin
      regRdData = 32'(statusR);
    end
  end

  // R3: starting with a zero count leaves the pending set untouched
  a_r3_zero_count_idle: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && chanHit && (slot == SLOT_CTRL) && regWrData[CTRL_EN_BIT] &&
     (cntReg[regCh][CNT_W-1:0] == '0) && !strb.finish) |=> $stable(pendingR));

  // R8: written ones are gone from status unless a completion raced them
  a_r8_status_w1c: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && statHit && !strb.finish) |=>
      ((statusR & $past(regWrData[NUM_CH-1:0])) == '0));

  // R10: writes to unmapped offsets disturb neither status nor pending
  a_r10_unmapped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !chanHit && !statHit && !strb.finish) |=>
      ($stable(statusR) && $stable(pendingR)));

endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
  import dma4_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_AW = 8,
  parameter logic [REG_AW-1:0] BASE = 'h80,
  parameter int CNT_W  = 16,
  localparam int CHSEL_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              memReq,
  output logic              memWe,
  output logic [63:0]       memAddr,
  output logic [1:0]        memSize,
  output logic [63:0]       memWdata,
  input  logic              memAck,
  input  logic [63:0]       memRdata
);

  dmaStrobe_t         strb;
  logic [CHSEL_W-1:0] selCh;
  logic [NUM_CH-1:0]  pending;
  logic               lastElem;

  dma4_ctrl #(.NUM_CH(NUM_CH)) ctrl_i (
    .clk(clk), .rstN(rstN), .pending(pending), .lastElem(lastElem),
    .memAck(memAck), .strb(strb), .selCh(selCh),
    .memReq(memReq), .memWe(memWe)
  );

  dma4_datapath #(.NUM_CH(NUM_CH), .REG_AW(REG_AW), .BASE(BASE), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .strb(strb), .selCh(selCh),
    .isWrite(memWe), .pending(pending), .lastElem(lastElem),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata), .memRdata(memRdata)
  );

endmodule

// File: tb/dma4_engine_tb_top.sv
module dma4_engine_tb_top;

  localparam logic [7:0] BASE = 8'h80;
  localparam int MEMSZ = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        memReq, memWe;
  logic [63:0] memAddr, memWdata;
  logic [1:0]  memSize;
  logic        memAck = 1'b0;
  logic [63:0] memRdata = '0;

  logic [7:0] mem  [MEMSZ];
  logic [7:0] refm [MEMSZ];
  int checks = 0, fails = 0, wdataBad = 0, sizeBad = 0, expSize = 0;

  always #5 clk = ~clk;

  dma4_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memSize(memSize), .memWdata(memWdata),
    .memAck(memAck), .memRdata(memRdata)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: random wait, little-endian byte lanes
  initial begin
    int waitCnt = 0;
    forever begin
      @(negedge clk);
      memAck = 1'b0;
      if (memReq && rstN) begin
        if (waitCnt > 0) waitCnt--;
        else begin
          memAck = 1'b1;
          waitCnt = $urandom % 3;
          if (int'(memSize) != expSize) sizeBad++;
          if (memWe) begin
            for (int b = 0; b < (1 << memSize); b++)
              mem[(memAddr + 64'(b)) % MEMSZ] = memWdata[8*b +: 8];
            if (memSize != 2'd3 && (memWdata >> (8 << memSize)) != 0) wdataBad++;
          end else begin
            memRdata = {$urandom, $urandom};
            for (int b = 0; b < (1 << memSize); b++)
              memRdata[8*b +: 8] = mem[(memAddr + 64'(b)) % MEMSZ];
          end
        end
      end
    end
  end

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  function automatic logic [7:0] chAddr(input int ch, input int slot);
    return BASE + 8'(ch * 8 + slot);
  endfunction

  function automatic logic [31:0] ctrlWord(input int code, input bit sInc, input bit dInc);
    return (32'd1 << 31) | (32'(dInc) << 24) | (32'(sInc) << 23) | (32'(code) << 25);
  endfunction

  // reference copy, element by element, read then write
  task automatic refXfer(input int code, input bit sInc, input bit dInc, input int cnt,
                         input int src, input int dst);
    int w = 1 << code;
    int s = src, d = dst;
    logic [7:0] tmp [8];
    for (int i = 0; i < cnt; i++) begin
      for (int b = 0; b < w; b++) tmp[b] = refm[(s + b) % MEMSZ];
      for (int b = 0; b < w; b++) refm[(d + b) % MEMSZ] = tmp[b];
      if (sInc) s += w;
      if (dInc) d += w;
    end
  endtask

  task automatic compareMem(input string req);
    int mism = 0;
    for (int i = 0; i < MEMSZ; i++) if (mem[i] !== refm[i]) mism++;
    check(mism == 0, req, 64'(mism), 64'd0);
  endtask

  task automatic waitStatus(input int bitn, output bit seen);
    logic [31:0] st;
    seen = 0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      regRead(BASE + 8'h20, st);
      seen = st[bitn];
    end
  endtask

  task automatic setupCh(input int ch, input int cnt, input logic [31:0] srcHi, input int src,
                         input int dst);
    regWrite(chAddr(ch, 1), 32'(cnt));
    regWrite(chAddr(ch, 2), srcHi);
    regWrite(chAddr(ch, 3), 32'(src));
    regWrite(chAddr(ch, 4), 32'h0);
    regWrite(chAddr(ch, 5), 32'(dst));
  endtask

  task automatic runXfer(input int ch, input int code, input bit sInc, input bit dInc,
                         input int cnt, input int src, input int dst, input string req);
    logic [31:0] rd, cw;
    bit seen;
    cw = ctrlWord(code, sInc, dInc);
    expSize = code;
    setupCh(ch, cnt, $urandom, src, dst);
    regWrite(chAddr(ch, 0), cw);
    regRead(chAddr(ch, 0), rd);
    check(rd == (cw | 32'h4000_0000), "R9 busy set after start", 64'(rd), 64'(cw | 32'h4000_0000));
    refXfer(code, sInc, dInc, cnt, src, dst);
    waitStatus(ch, seen);
    check(seen, "R8 status set on completion", 64'(seen), 64'd1);
    regRead(chAddr(ch, 0), rd);
    check(rd == cw, "R9 busy clear after finish", 64'(rd), 64'(cw));
    compareMem(req);
    regWrite(BASE + 8'h20, 32'hF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R6 actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    bit seen;
    void'($urandom(32'd1234));
    for (int i = 0; i < MEMSZ; i++) begin mem[i] = 8'($urandom); refm[i] = mem[i]; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R11 reset state
    regRead(chAddr(0, 0), rd); check(rd == 0, "R11 ctrl after reset", 64'(rd), 0);
    regRead(BASE + 8'h20, rd); check(rd == 0, "R11 status after reset", 64'(rd), 0);
    check(memReq == 0, "R11 no request after reset", 64'(memReq), 0);

    // R1 / R2 address halves and chain registers
    regWrite(chAddr(1, 6), 32'hDEAD_BEEF);
    regWrite(chAddr(1, 7), 32'h1234_5678);
    regRead(chAddr(1, 6), rd); check(rd == 32'hDEAD_BEEF, "R1 chain high readback", 64'(rd), 64'hDEAD_BEEF);
    regRead(chAddr(1, 7), rd); check(rd == 32'h1234_5678, "R1 chain low readback", 64'(rd), 64'h1234_5678);
    regWrite(chAddr(2, 4), 32'hAAAA_0001);
    regWrite(chAddr(2, 5), 32'h5555_0002);
    regWrite(chAddr(2, 4), 32'hCCCC_0003);
    regRead(chAddr(2, 5), rd); check(rd == 32'h5555_0002, "R2 low half kept", 64'(rd), 64'h5555_0002);
    regRead(chAddr(2, 4), rd); check(rd == 32'hCCCC_0003, "R2 high half replaced", 64'(rd), 64'hCCCC_0003);

    // R10 unmapped offsets
    regWrite(BASE + 8'h21, 32'hFFFF_FFFF);
    regRead(BASE + 8'h21, rd); check(rd == 0, "R10 unmapped reads zero", 64'(rd), 0);
    regWrite(8'h10, 32'hFFFF_FFFF);
    regRead(BASE + 8'h20, rd); check(rd == 0, "R10 unmapped write ignored", 64'(rd), 0);

    // R3 zero count: nothing moves
    setupCh(2, 0, 0, 10, 600);
    regWrite(chAddr(2, 0), ctrlWord(0, 1, 1));
    repeat (20) @(negedge clk);
    regRead(chAddr(2, 0), rd); check(rd[30] == 0, "R3 zero count not busy", 64'(rd[30]), 0);
    regRead(BASE + 8'h20, rd); check(rd == 0, "R3 zero count no status", 64'(rd), 0);
    compareMem("R3 zero count memory untouched");

    // directed: width and stepping corners
    runXfer(0, 3, 1, 1, 5, 16, 520, "R4 eight-byte copy");
    runXfer(1, 0, 0, 1, 6, 40, 600, "R5 fixed source");
    runXfer(3, 2, 1, 0, 4, 80, 700, "R5 fixed destination");
    runXfer(2, 1, 1, 1, 1, 3, 801, "R7 single unaligned halfword");
    runXfer(0, 2, 1, 1, 6, 100, 104, "R7 overlapping forward copy");

    // R6 priority: ch3 active, then ch2 and ch1 queued
    expSize = 0;
    setupCh(3, 30, 0, 200, 900);
    regWrite(chAddr(3, 0), ctrlWord(0, 1, 1));
    setupCh(2, 3, 0, 300, 940);
    regWrite(chAddr(2, 0), ctrlWord(0, 1, 1));
    setupCh(1, 3, 0, 320, 960);
    regWrite(chAddr(1, 0), ctrlWord(0, 1, 1));
    refXfer(0, 1, 1, 30, 200, 900);
    refXfer(0, 1, 1, 3, 320, 960);
    refXfer(0, 1, 1, 3, 300, 940);
    waitStatus(1, seen);
    regRead(BASE + 8'h20, rd);
    check(seen && rd[3:0] == 4'b1010, "R6 lower channel served first", 64'(rd), 64'hA);
    waitStatus(2, seen);
    check(seen, "R6 queued channel completes", 64'(seen), 1);
    compareMem("R6 queued copies");
    // R8 clear with partial mask
    regWrite(BASE + 8'h20, 32'h2);
    regRead(BASE + 8'h20, rd); check(rd[3:0] == 4'b1100, "R8 write-one clears only its bit", 64'(rd), 64'hC);
    regWrite(BASE + 8'h20, 32'hF);

    // random transfers
    for (int k = 0; k < 16; k++) begin
      runXfer($urandom % 4, $urandom % 4, 1'($urandom), 1'($urandom),
              1 + $urandom % 8, $urandom % 400, 512 + $urandom % 400, "R3 random copy");
    end

    check(wdataBad == 0, "R7 upper write bits zero", 64'(wdataBad), 0);
    check(sizeBad == 0, "R4 memSize matches code", 64'(sizeBad), 0);

    // R11 reset mid-transfer
    setupCh(0, 200, 0, 0, 512);
    regWrite(chAddr(0, 0), ctrlWord(3, 1, 1));
    repeat (10) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(memReq == 0, "R11 transfer aborted", 64'(memReq), 0);
    regRead(chAddr(0, 1), rd); check(rd == 0, "R11 count cleared", 64'(rd), 0);
    regRead(chAddr(0, 0), rd); check(rd == 0, "R11 ctrl cleared", 64'(rd), 0);
    regWrite(chAddr(3, 3), 32'h0BAD_F00D);
    regRead(chAddr(3, 3), rd); check(rd == 32'h0BAD_F00D, "R11 base kept", 64'(rd), 64'h0BAD_F00D);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule